// File: doc/BRIEF.md
# Fractional Q15 Multiply-Accumulate Unit

This block multiplies signed Q15 fractions taken out of 32-bit operand words and returns the result in Q31 form. It can also narrow that result back to a single Q15 halfword, or add it into a 64-bit running sum. A fractional product needs an ordinary signed 16x16 multiply and then a doubling step. The doubling step saturates, so the one input pair that would overflow (minus one times minus one) clamps to the largest positive Q31 value and does not wrap. Each operand word carries two halfwords, and a select bit for each operand picks which half takes part. In dual mode both pairs of halves are multiplied at once: upper with upper and lower with lower.

The unit has two pipeline stages. The first stage selects the operands and multiplies them. The second stage doubles, narrows and accumulates. A transfer accepted with `in_valid` shows its results, together with `out_valid`, two clock edges later. The accumulator is read as an upper and a lower 32-bit word. `acc_clr` starts a new sum from the current products. A sticky flag records every saturation event until the next reset.

Top module: `q15_mac`

## Requirements
- R1: Outside dual mode, each operand's halfword is chosen on its own: select bit 1 takes bits [31:16] of the word and select bit 0 takes bits [15:0].
- R2: `q31_a` equals twice the signed product of the selected halves. The product 0x8000 x 0x8000 gives 0x7FFFFFFF.
- R3: `sat_flag` rises when a doubling saturates or when a rounding overflows. It stays high until reset.
- R4: With `round_en` = 0, `q15_out` equals bits [31:16] of `q31_a`.
- R5: With `round_en` = 1, `q15_out` equals bits [31:16] of (`q31_a` + 0x8000). When that sum exceeds 0x7FFFFFFF, `q15_out` is 0x7FFF.
- R6: With `dual_en` = 1, the select bits are ignored. Lane A is bits [31:16] of `a_word` times bits [31:16] of `b_word`, and lane B (`q31_b`) is bits [15:0] of `a_word` times bits [15:0] of `b_word`, each doubled with saturation. With `dual_en` = 0, `q31_b` is 0.
- R7: With `acc_en` = 1, the 64-bit sum {`acc_hi`,`acc_lo`} grows by the sign-extended `q31_a` plus `q31_b`. The sum wraps modulo 2^64.
- R8: With `acc_en` = 1 and `acc_clr` = 1, the sum is loaded with the sign-extended `q31_a` plus `q31_b`, and the old value is dropped.
- R9: Results and `out_valid` appear two rising edges after `in_valid`. A cycle with `in_valid` low raises no `out_valid`, and all outputs keep their values.
- R10: A valid transfer with `acc_en` = 0 leaves the accumulator unchanged.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls valid this cycle |
| a_word | input | 32 | First operand word, two packed halfwords |
| b_word | input | 32 | Second operand word, two packed halfwords |
| a_hi_sel | input | 1 | 1: upper half of `a_word`, 0: lower half |
| b_hi_sel | input | 1 | 1: upper half of `b_word`, 0: lower half |
| dual_en | input | 1 | Multiply both half pairs together |
| acc_en | input | 1 | Add products into the running sum |
| round_en | input | 1 | 1: round when narrowing, 0: truncate |
| acc_clr | input | 1 | Load the sum with the products in place of the old sum |
| out_valid | output | 1 | Results updated this cycle |
| q31_a | output | 32 | Lane A doubled product, Q31 |
| q31_b | output | 32 | Lane B doubled product, Q31 (dual mode only) |
| q15_out | output | 16 | Lane A narrowed to Q15 |
| acc_hi | output | 32 | Upper word of the running sum |
| acc_lo | output | 32 | Lower word of the running sum |
| sat_flag | output | 1 | Sticky saturation indication |

## Verification
The main corner case is minus one squared. A design that doubles with a plain shift returns 0x80000000 there and leaves the flag low. Rounding just below full scale is the next target. A missing overflow clamp wraps `q15_out` to 0x8000, and adding the carry at the wrong bit shifts every rounded value by one. Dual operations with lopsided half values expose swapped lanes or select bits that still act in dual mode. Runs of accumulate, clear and non-accumulating transfers, with idle gaps in between, expose a sum that ignores the clear or drifts on cycles that should leave it alone.

// File: rtl/q15_mac_pkg.sv
`timescale 1ns/1ps
package q15_mac_pkg;

    // Default halfword width; operand words, products and the sum scale from it.
    parameter int unsigned HALF_W_DEF = 16;

    // How a Q31 lane result is narrowed to a single halfword.
    typedef enum logic {
        NRW_TRUNC = 1'b0,
        NRW_ROUND = 1'b1
    } narrow_e;

endpackage

// File: rtl/q15_half_pick.sv
`timescale 1ns/1ps
module q15_half_pick #(
    parameter  int unsigned HALF_W = 16,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              hi_sel_i,
    output logic [HALF_W-1:0] half_o
);

    // Upper or lower halfword of a packed word.
    always_comb begin
        if (hi_sel_i) begin
            half_o = word_i[WORD_W-1:HALF_W];
        end else begin
            half_o = word_i[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/q15_sat_double.sv
`timescale 1ns/1ps
module q15_sat_double #(
    parameter int unsigned PROD_W = 32
) (
    input  logic [PROD_W-1:0] prod_i,
    output logic [PROD_W-1:0] dbl_o,
    output logic              sat_o
);

    // Doubling overflows when the two top bits differ; clamp to the
    // extreme value with the sign of the product.
    always_comb begin
        sat_o = prod_i[PROD_W-1] ^ prod_i[PROD_W-2];
        if (sat_o) begin
            if (prod_i[PROD_W-1]) begin
                dbl_o = {1'b1, {(PROD_W-1){1'b0}}};
            end else begin
                dbl_o = {1'b0, {(PROD_W-1){1'b1}}};
            end
        end else begin
            dbl_o = {prod_i[PROD_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/q15_mul_stage.sv
`timescale 1ns/1ps
module q15_mul_stage
    import q15_mac_pkg::*;
#(
    parameter  int unsigned HALF_W = 16,
    localparam int unsigned PROD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [HALF_W-1:0] a_x_i,
    input  logic [HALF_W-1:0] a_y_i,
    input  logic [HALF_W-1:0] b_x_i,
    input  logic [HALF_W-1:0] b_y_i,
    input  logic              dual_i,
    input  logic              acc_i,
    input  narrow_e           rnd_i,
    input  logic              clr_i,
    output logic              valid_o,
    output logic [PROD_W-1:0] prod_a_o,
    output logic [PROD_W-1:0] prod_b_o,
    output logic              acc_o,
    output narrow_e           rnd_o,
    output logic              clr_o
);

    typedef struct packed {
        logic              valid;
        logic [PROD_W-1:0] prod_a;
        logic [PROD_W-1:0] prod_b;
        logic              acc;
        narrow_e           rnd;
        logic              clr;
    } s1_t;

    s1_t s1_d, s1_q;

    function automatic logic [PROD_W-1:0] smul(input logic [HALF_W-1:0] x,
                                               input logic [HALF_W-1:0] y);
        logic signed [PROD_W-1:0] xs, ys;
        xs = PROD_W'($signed(x));
        ys = PROD_W'($signed(y));
        return xs * ys;
    endfunction

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = valid_i;
        if (valid_i) begin
            s1_d.prod_a = smul(a_x_i, a_y_i);
            s1_d.prod_b = dual_i ? smul(b_x_i, b_y_i) : '0;
            s1_d.acc    = acc_i;
            s1_d.rnd    = rnd_i;
            s1_d.clr    = clr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '{valid: 1'b0, prod_a: '0, prod_b: '0, acc: 1'b0,
                      rnd: NRW_TRUNC, clr: 1'b0};
        end else begin
            s1_q <= s1_d;
        end
    end

    assign valid_o  = s1_q.valid;
    assign prod_a_o = s1_q.prod_a;
    assign prod_b_o = s1_q.prod_b;
    assign acc_o    = s1_q.acc;
    assign rnd_o    = s1_q.rnd;
    assign clr_o    = s1_q.clr;

    // R6: a single-lane transfer leaves the second lane product at zero
    p_single_lane_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dual_i) |=> (prod_b_o == '0));

    // R9: the first stage flags exactly the accepted cycles
    p_stage1_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

endmodule

// File: rtl/q15_post_stage.sv
`timescale 1ns/1ps
module q15_post_stage
    import q15_mac_pkg::*;
#(
    parameter  int unsigned HALF_W = 16,
    localparam int unsigned PROD_W = 2 * HALF_W,
    localparam int unsigned ACC_W  = 4 * HALF_W,
    localparam int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [PROD_W-1:0] prod_a_i,
    input  logic [PROD_W-1:0] prod_b_i,
    input  logic              acc_i,
    input  narrow_e           rnd_i,
    input  logic              clr_i,
    output logic              valid_o,
    output logic [PROD_W-1:0] q31_a_o,
    output logic [PROD_W-1:0] q31_b_o,
    output logic [HALF_W-1:0] q15_o,
    output logic [ACC_W-1:0]  acc_o,
    output logic              sat_o
);

    localparam logic [HALF_W-1:0] HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};

    typedef struct packed {
        logic              valid;
        logic [PROD_W-1:0] q31_a;
        logic [PROD_W-1:0] q31_b;
        logic [HALF_W-1:0] q15;
        logic [ACC_W-1:0]  acc;
        logic              sat;
    } s2_t;

    s2_t s2_d, s2_q;

    logic [LANES-1:0][PROD_W-1:0] lane_prod;
    logic [LANES-1:0][PROD_W-1:0] lane_dbl;
    logic [LANES-1:0]             lane_sat;

    always_comb begin
        lane_prod[0] = prod_a_i;
        lane_prod[1] = prod_b_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        q15_sat_double #(.PROD_W(PROD_W)) u_dbl (
            .prod_i (lane_prod[g]),
            .dbl_o  (lane_dbl[g]),
            .sat_o  (lane_sat[g])
        );
    end

    logic [HALF_W-1:0] hi_part;
    logic              rnd_bit;
    logic              rnd_ovf;
    logic [HALF_W-1:0] narrow;
    logic [ACC_W-1:0]  addend;

    always_comb begin
        // Adding half an LSB and keeping the top half is the same as
        // adding the bit just below the kept field into that field.
        hi_part = lane_dbl[0][PROD_W-1:HALF_W];
        rnd_bit = lane_dbl[0][HALF_W-1];
        rnd_ovf = (rnd_i == NRW_ROUND) && rnd_bit && (hi_part == HALF_MAX);
        if (rnd_i == NRW_ROUND) begin
            narrow = rnd_ovf ? HALF_MAX : hi_part + HALF_W'(rnd_bit);
        end else begin
            narrow = hi_part;
        end
        addend = ACC_W'($signed(lane_dbl[0])) + ACC_W'($signed(lane_dbl[1]));

        s2_d       = s2_q;
        s2_d.valid = valid_i;
        if (valid_i) begin
            s2_d.q31_a = lane_dbl[0];
            s2_d.q31_b = lane_dbl[1];
            s2_d.q15   = narrow;
            s2_d.sat   = s2_q.sat | (|lane_sat) | rnd_ovf;
            if (acc_i) begin
                s2_d.acc = clr_i ? addend : s2_q.acc + addend;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_q <= '0;
        end else begin
            s2_q <= s2_d;
        end
    end

    assign valid_o = s2_q.valid;
    assign q31_a_o = s2_q.q31_a;
    assign q31_b_o = s2_q.q31_b;
    assign q15_o   = s2_q.q15;
    assign acc_o   = s2_q.acc;
    assign sat_o   = s2_q.sat;

    // R2: minus one squared from the multiplier clamps to full scale and flags
    p_neg_one_sq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && prod_a_i == {2'b01, {(PROD_W-2){1'b0}}})
        |=> (q31_a_o == {1'b0, {(PROD_W-1){1'b1}}}) && sat_o);

    // R3: the saturation flag never drops without reset
    p_sat_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |=> sat_o);

    // R9: output valid follows stage-one valid by one edge, both ways
    p_out_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    // R10: non-accumulating or idle cycles keep the sum
    p_acc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && acc_i) |=> $stable(acc_o));

endmodule

// File: rtl/q15_mac.sv
`timescale 1ns/1ps
module q15_mac
    import q15_mac_pkg::*;
#(
    parameter  int unsigned HALF_W = q15_mac_pkg::HALF_W_DEF,
    localparam int unsigned WORD_W = 2 * HALF_W,
    localparam int unsigned ACC_W  = 4 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic              a_hi_sel,
    input  logic              b_hi_sel,
    input  logic              dual_en,
    input  logic              acc_en,
    input  logic              round_en,
    input  logic              acc_clr,
    output logic              out_valid,
    output logic [WORD_W-1:0] q31_a,
    output logic [WORD_W-1:0] q31_b,
    output logic [HALF_W-1:0] q15_out,
    output logic [WORD_W-1:0] acc_hi,
    output logic [WORD_W-1:0] acc_lo,
    output logic              sat_flag
);

    logic              sel_a_hi, sel_b_hi;
    logic [HALF_W-1:0] lane_a_x, lane_a_y;
    narrow_e           rnd_mode;

    // Dual mode forces lane A onto the upper halves; lane B always uses the lower halves.
    always_comb begin
        sel_a_hi = dual_en | a_hi_sel;
        sel_b_hi = dual_en | b_hi_sel;
        rnd_mode = round_en ? NRW_ROUND : NRW_TRUNC;
    end

    q15_half_pick #(.HALF_W(HALF_W)) u_pick_a (
        .word_i   (a_word),
        .hi_sel_i (sel_a_hi),
        .half_o   (lane_a_x)
    );

    q15_half_pick #(.HALF_W(HALF_W)) u_pick_b (
        .word_i   (b_word),
        .hi_sel_i (sel_b_hi),
        .half_o   (lane_a_y)
    );

    logic              s1_valid, s1_acc, s1_clr;
    logic [WORD_W-1:0] s1_prod_a, s1_prod_b;
    narrow_e           s1_rnd;

    q15_mul_stage #(.HALF_W(HALF_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (in_valid),
        .a_x_i    (lane_a_x),
        .a_y_i    (lane_a_y),
        .b_x_i    (a_word[HALF_W-1:0]),
        .b_y_i    (b_word[HALF_W-1:0]),
        .dual_i   (dual_en),
        .acc_i    (acc_en),
        .rnd_i    (rnd_mode),
        .clr_i    (acc_clr),
        .valid_o  (s1_valid),
        .prod_a_o (s1_prod_a),
        .prod_b_o (s1_prod_b),
        .acc_o    (s1_acc),
        .rnd_o    (s1_rnd),
        .clr_o    (s1_clr)
    );

    logic [ACC_W-1:0] acc_sum;

    q15_post_stage #(.HALF_W(HALF_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (s1_valid),
        .prod_a_i (s1_prod_a),
        .prod_b_i (s1_prod_b),
        .acc_i    (s1_acc),
        .rnd_i    (s1_rnd),
        .clr_i    (s1_clr),
        .valid_o  (out_valid),
        .q31_a_o  (q31_a),
        .q31_b_o  (q31_b),
        .q15_o    (q15_out),
        .acc_o    (acc_sum),
        .sat_o    (sat_flag)
    );

    assign acc_hi = acc_sum[ACC_W-1:WORD_W];
    assign acc_lo = acc_sum[WORD_W-1:0];

endmodule

// File: tb/q15_mac_bench.sv
`timescale 1ns/1ps
module q15_mac_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] a_word = '0, b_word = '0;
    logic        a_hi_sel = 1'b0, b_hi_sel = 1'b0, dual_en = 1'b0;
    logic        acc_en = 1'b0, round_en = 1'b0, acc_clr = 1'b0;
    logic        out_valid, sat_flag;
    logic [31:0] q31_a, q31_b, acc_hi, acc_lo;
    logic [15:0] q15_out;

    always #10 clk = ~clk;

    q15_mac u_q15_mac (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_word(a_word), .b_word(b_word), .a_hi_sel(a_hi_sel), .b_hi_sel(b_hi_sel),
        .dual_en(dual_en), .acc_en(acc_en), .round_en(round_en), .acc_clr(acc_clr),
        .out_valid(out_valid), .q31_a(q31_a), .q31_b(q31_b), .q15_out(q15_out),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .sat_flag(sat_flag)
    );

    typedef struct {
        logic        vld;
        logic [31:0] qa;
        logic [31:0] qb;
        logic [15:0] qn;
        logic [63:0] acc;
        logic        sat;
    } exp_t;

    exp_t pend0, pend1, mst;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    function automatic exp_t zero_state();
        exp_t z;
        z.vld = 0; z.qa = '0; z.qb = '0; z.qn = '0; z.acc = '0; z.sat = 0;
        return z;
    endfunction

    // Doubled signed product, clamped to the Q31 range.
    function automatic logic [31:0] f_dbl(input logic signed [15:0] x,
                                          input logic signed [15:0] y,
                                          output logic s);
        longint p;
        p = longint'(x) * longint'(y) * 2;
        s = 0;
        if (p > 64'sd2147483647) begin
            s = 1;
            return 32'h7FFF_FFFF;
        end
        return p[31:0];
    endfunction

    function automatic logic [15:0] f_narrow(input logic [31:0] q, input logic rn,
                                             output logic s);
        longint v, r;
        s = 0;
        v = longint'($signed(q));
        if (!rn) return q[31:16];
        r = v + 64'sd32768;
        if (r > 64'sd2147483647) begin
            s = 1;
            return 16'h7FFF;
        end
        r = r >>> 16;
        return r[15:0];
    endfunction

    task automatic chk(input string tag, input string fld,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
        end
    endtask

    // One cycle: check the transfer issued two steps back, then issue a new one.
    task automatic step(input string tag, input logic v,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic ah, input logic bh, input logic du,
                        input logic ac, input logic rn, input logic cl);
        exp_t nx;
        logic signed [15:0] xa, ya;
        logic s0, s1, s2;
        longint add;
        @(negedge clk);
        chk(tag, "out_valid R9", {63'd0, out_valid}, {63'd0, pend1.vld});
        if (pend1.vld) begin
            chk(tag, "q31_a R2", {32'd0, q31_a}, {32'd0, pend1.qa});
            chk(tag, "q31_b R6", {32'd0, q31_b}, {32'd0, pend1.qb});
            chk(tag, "q15_out R4 R5", {48'd0, q15_out}, {48'd0, pend1.qn});
        end
        chk(tag, "accumulator R7", {acc_hi, acc_lo}, pend1.acc);
        chk(tag, "sat_flag R3", {63'd0, sat_flag}, {63'd0, pend1.sat});
        pend1 = pend0;
        nx = mst;
        nx.vld = v;
        if (v) begin
            xa = du ? a[31:16] : (ah ? a[31:16] : a[15:0]);
            ya = du ? b[31:16] : (bh ? b[31:16] : b[15:0]);
            nx.qa = f_dbl(xa, ya, s0);
            s1 = 0;
            nx.qb = du ? f_dbl(a[15:0], b[15:0], s1) : 32'd0;
            nx.qn = f_narrow(nx.qa, rn, s2);
            nx.sat = mst.sat | s0 | s1 | s2;
            if (ac) begin
                add = longint'($signed(nx.qa)) + longint'($signed(nx.qb));
                nx.acc = cl ? add : nx.acc + add;
            end
        end
        pend0 = nx;
        mst = nx;
        in_valid = v; a_word = a; b_word = b; a_hi_sel = ah; b_hi_sel = bh;
        dual_en = du; acc_en = ac; round_en = rn; acc_clr = cl;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; acc_en = 0; acc_clr = 0; dual_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        pend0 = zero_state(); pend1 = zero_state(); mst = zero_state();
    endtask

    task automatic drain();
        repeat (3) step("drain", 0, 32'hDEAD_BEEF, 32'h1234_5678, 1, 0, 1, 1, 1, 1);
    endtask

    initial begin
        logic [31:0] r, a, b;
        void'($urandom(32'd1357));
        pend0 = zero_state(); pend1 = zero_state(); mst = zero_state();
        do_reset();
        // R11: outputs at zero after reset
        step("R11 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R11 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R1: all four half-select combinations on unequal halves
        step("R1 hh", 1, 32'h4000_2000, 32'h1000_C000, 1, 1, 0, 0, 0, 0);
        step("R1 hl", 1, 32'h4000_2000, 32'h1000_C000, 1, 0, 0, 0, 0, 0);
        step("R1 lh", 1, 32'h4000_2000, 32'h1000_C000, 0, 1, 0, 0, 0, 0);
        step("R1 ll", 1, 32'h4000_2000, 32'h1000_C000, 0, 0, 0, 0, 0, 0);
        // R4 / R5: truncation versus rounding, positive and negative fractions
        step("R4 trunc", 1, 32'h0000_4001, 32'h0000_0003, 0, 0, 0, 0, 0, 0);
        step("R5 round", 1, 32'h0000_4001, 32'h0000_0003, 0, 0, 0, 0, 1, 0);
        step("R4 trunc neg", 1, 32'h0000_C001, 32'h0000_0003, 0, 0, 0, 0, 0, 0);
        step("R5 round neg", 1, 32'h0000_C001, 32'h0000_0003, 0, 0, 0, 0, 1, 0);
        step("R5 round near max", 1, 32'h7FFF_0000, 32'h7FFF_0000, 1, 1, 0, 0, 1, 0);
        step("R5 max neg", 1, 32'h8000_0000, 32'h7FFF_0000, 1, 1, 0, 0, 1, 0);
        // R8 / R7: clear then accumulate, including negative products
        step("R8 clear load", 1, 32'h2000_0000, 32'h4000_0000, 1, 1, 0, 1, 0, 1);
        step("R7 accumulate", 1, 32'h0000_3000, 32'h0000_9000, 0, 0, 0, 1, 0, 0);
        step("R7 accumulate", 1, 32'h7FFF_0000, 32'h0000_7FFF, 1, 0, 0, 1, 0, 0);
        // R10: products computed, sum kept
        step("R10 no acc", 1, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1, 1, 1, 0, 0, 0);
        // R9: idle cycles with busy inputs change nothing
        step("R9 idle", 0, 32'h8000_8000, 32'h8000_8000, 1, 1, 1, 1, 1, 1);
        step("R9 idle", 0, 32'h8000_8000, 32'h8000_8000, 1, 1, 1, 1, 1, 1);
        // R6: dual lanes with lopsided halves, select bits set opposite
        step("R6 dual", 1, 32'h4000_F000, 32'h2000_0800, 0, 0, 1, 1, 0, 0);
        step("R6 dual clr", 1, 32'hC000_1000, 32'h6000_E000, 0, 1, 1, 1, 1, 1);
        step("R10 no acc", 1, 32'h1111_2222, 32'h3333_4444, 0, 0, 0, 0, 0, 0);
        // R2 / R3: minus one squared clamps and raises the sticky flag
        step("R2 neg one sq", 1, 32'h8000_0000, 32'h0000_8000, 1, 0, 0, 1, 0, 0);
        step("R3 sticky", 1, 32'h0000_0100, 32'h0000_0100, 0, 0, 0, 1, 0, 0);
        drain();
        // R5 / R3: rounding the clamped value also clamps; dual lane B clamp
        do_reset();
        step("R11 reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R5 round clamp", 1, 32'h0000_8000, 32'h0000_8000, 0, 0, 0, 0, 1, 0);
        drain();
        do_reset();
        step("R6 lane b clamp", 1, 32'h1000_8000, 32'h1000_8000, 0, 0, 1, 1, 0, 1);
        drain();
        // Random mix
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            a = $urandom;
            b = $urandom;
            if (r[3:0] == 4'd0) begin a[31:16] = 16'h8000; b[31:16] = 16'h8000; end
            if (r[7:4] == 4'd0) begin a[15:0] = 16'h8000; b[15:0] = 16'h8000; end
            step("random R1 R6 R7 R8", r[10:8] != 3'd0, a, b, r[11], r[12], r[13],
                 r[14] | r[15], r[16], r[19:17] == 3'd0);
        end
        drain();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R9: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule